// File: doc/BRIEF.md
# Flash Reset and Ready/Busy Sequencer

This block sits beside the command engine of a byte-wide flash array. It watches the active-low hardware reset pin (`hwResetN`) and the busy flag of the embedded program/erase engine. A reset pulse counts only after it has been sampled low on `PULSE_MIN` consecutive clock edges. The edge on which the pulse is accepted is the acceptance edge. On that edge the block asks the engine to abort if the engine is busy, and it tells the command decoder to return to read-array mode. It then holds the data bus tristated and marks every host access as ignored until the internal reset has finished and the pin has been released for long enough.

The internal reset takes longer when an embedded operation was interrupted. It takes `LONG_RECOV` cycles in that case and `SHORT_RECOV` cycles otherwise. The ready/busy output is held at busy for the whole of a long recovery, so the host can poll it to see when the reset is complete. Outside a long recovery, ready/busy simply reports the engine's busy flag. If reset is accepted again while a recovery is still running, the sequence starts over. A long recovery that is still running stays long.

Top module: `flash_reset_seq`

## Requirements
- R1: After the system reset `rstN`, `abortReq`, `readArrayCmd`, `busTristate` and `accessIgnore` are 0, and `rdyBusy` equals the inverse of `engineBusy`.
- R2: If `hwResetN` is low on fewer than `PULSE_MIN` consecutive sampled edges, no output differs from what it would be had the pin stayed high.
- R3: `abortReq` is 1 for exactly the one cycle after the acceptance edge, and only when `engineBusy` was 1 on that edge. Otherwise it stays 0.
- R4: `readArrayCmd` is 1 for exactly the one cycle after every acceptance edge, whether or not the engine was busy.
- R5: `busTristate` and `accessIgnore` rise to 1 in the cycle after the acceptance edge. They stay at 1 for as long as `hwResetN` is sampled low.
- R6: If `engineBusy` was 1 on the acceptance edge, `rdyBusy` is 0 for exactly `LONG_RECOV` cycles after that edge, whatever `engineBusy` does during that time.
- R7: If `engineBusy` was 0 on the acceptance edge and no long recovery was running, the recovery lasts `SHORT_RECOV` cycles and `rdyBusy` stays at 1 while `engineBusy` is 0.
- R8: `busTristate` and `accessIgnore` return to 0 on the first edge that meets two conditions: `hwResetN` has been sampled high on `READ_HOLD` consecutive edges, and the recovery count (long or short) since the last acceptance edge has expired.
- R9: An acceptance edge during a running sequence restarts both counts from that edge. The new recovery is long if the engine was busy on that edge or if a long recovery was still running.
- R10: Outside a long recovery, `rdyBusy` is the inverse of `engineBusy`, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset of the sequencer |
| hwResetN | input | 1 | Active-low hardware reset pin, sampled synchronously |
| engineBusy | input | 1 | Embedded program/erase engine is running |
| abortReq | output | 1 | One-cycle request to the engine to abort its operation |
| readArrayCmd | output | 1 | One-cycle request to the command decoder to return to read-array mode |
| busTristate | output | 1 | 1 = data output drivers must be off |
| accessIgnore | output | 1 | 1 = host reads and writes must be dropped |
| rdyBusy | output | 1 | Ready/busy: 1 ready, 0 busy |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- **Glitch of `PULSE_MIN`-1 lows while the engine is busy.** An off-by-one in the pulse filter would abort the engine on this glitch.
- **Busy-flag drop after the abort.** The engine drops its busy flag in the cycle after the abort. A design that derived ready/busy from the engine flag alone would report ready far too early.
- **Idle reset with a quick release.** The recovery count, not the release hold, sets when access resumes. A design that watched only the pin would reopen the bus before the internal reset was done.
- **Idle reset with a long release.** The release hold sets when access resumes instead, and the length of the pulse must not change the recovery count.
- **Re-acceptance inside a recovery.** A design that failed to reload its counters, or that lost the long mode on restart, would end the sequence or release ready/busy at the wrong cycle.

// File: rtl/flash_reset_pkg.sv
package flash_reset_pkg;
  // Strobes from the control module to the counting datapath.
  typedef struct packed {
    logic accept;    // reset pulse accepted on this edge
    logic pickLong;  // recovery loaded on this edge is the long one
  } rstStrobe_t;
endpackage

// File: rtl/flash_reset_ctrl.sv
module flash_reset_ctrl
  import flash_reset_pkg::*;
#(
  parameter int PULSE_MIN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwResetN,
  input  logic       engineBusy,
  input  logic       longBusy,
  input  logic       drainDone,
  output rstStrobe_t strb,
  output logic       seqActive,
  output logic       abortReq,
  output logic       readArrayCmd
);
  localparam int PW = $clog2(PULSE_MIN + 1);
  localparam logic [PW-1:0] LOW_SAT  = PW'(PULSE_MIN);
  localparam logic [PW-1:0] LOW_LAST = PW'(PULSE_MIN - 1);

  logic [PW-1:0] lowCnt;

  always_comb begin
    strb.accept   = !hwResetN && (lowCnt == LOW_LAST);
    strb.pickLong = engineBusy || longBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt       <= '0;
      seqActive    <= 1'b0;
      abortReq     <= 1'b0;
      readArrayCmd <= 1'b0;
    end else begin
      if (hwResetN)              lowCnt <= '0;
      else if (lowCnt != LOW_SAT) lowCnt <= lowCnt + 1'b1;
      abortReq     <= strb.accept && engineBusy;
      readArrayCmd <= strb.accept;
      seqActive    <= strb.accept || (seqActive && !drainDone);
    end
  end

  // A sequence only starts together with a read-array command
  assert_start_with_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqActive) |-> readArrayCmd);
  // An abort is always accompanied by the return to read-array mode
  assert_abort_with_cmd_R3: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> readArrayCmd);
  // The read-array command is a single-cycle pulse
  assert_cmd_one_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    readArrayCmd |=> !readArrayCmd);
  // Access may resume only after the pin was seen high
  assert_release_on_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(seqActive) |-> $past(hwResetN));
endmodule

// File: rtl/flash_reset_dp.sv
module flash_reset_dp
  import flash_reset_pkg::*;
#(
  parameter int LONG_RECOV  = 20,
  parameter int SHORT_RECOV = 6,
  parameter int READ_HOLD   = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwResetN,
  input  rstStrobe_t strb,
  output logic       longBusy,
  output logic       drainDone
);
  localparam int MAXV = (LONG_RECOV > READ_HOLD) ? LONG_RECOV : READ_HOLD;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_RECOV);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_RECOV);
  localparam logic [CW-1:0] HOLD_V  = CW'(READ_HOLD);

  logic [CW-1:0] recCnt, holdCnt, recNext, holdNext;
  logic          longNext;

  always_comb begin
    if (strb.accept)       recNext = strb.pickLong ? LONG_V : SHORT_V;
    else if (recCnt != '0) recNext = recCnt - 1'b1;
    else                   recNext = '0;

    if (!hwResetN)          holdNext = HOLD_V;
    else if (holdCnt != '0) holdNext = holdCnt - 1'b1;
    else                    holdNext = '0;

    longNext  = strb.accept ? strb.pickLong : (longBusy && (recCnt > CW'(1)));
    drainDone = (recNext == '0) && (holdNext == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recCnt   <= '0;
      holdCnt  <= '0;
      longBusy <= 1'b0;
    end else begin
      recCnt   <= recNext;
      holdCnt  <= holdNext;
      longBusy <= longNext;
    end
  end

  // Recovery counts down one per cycle unless reloaded
  assert_rec_countdown_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.accept && recCnt != '0) |=> (recCnt == $past(recCnt) - CW'(1)));
  // Long busy never outlives its count
  assert_long_has_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    longBusy |-> (recCnt != '0));
  // Any low sample rearms the release hold
  assert_hold_rearm_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hwResetN |=> (holdCnt == HOLD_V));
endmodule

// File: rtl/flash_reset_seq.sv
module flash_reset_seq
  import flash_reset_pkg::*;
#(
  parameter int PULSE_MIN   = 4,   // >= 1
  parameter int LONG_RECOV  = 20,  // >= SHORT_RECOV, >= 1
  parameter int SHORT_RECOV = 6,
  parameter int READ_HOLD   = 3    // >= 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic hwResetN,
  input  logic engineBusy,
  output logic abortReq,
  output logic readArrayCmd,
  output logic busTristate,
  output logic accessIgnore,
  output logic rdyBusy
);
  rstStrobe_t strb;
  logic longBusy, drainDone, seqActive;

  flash_reset_ctrl #(.PULSE_MIN(PULSE_MIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .hwResetN(hwResetN), .engineBusy(engineBusy),
    .longBusy(longBusy), .drainDone(drainDone), .strb(strb),
    .seqActive(seqActive), .abortReq(abortReq), .readArrayCmd(readArrayCmd)
  );

  flash_reset_dp #(
    .LONG_RECOV(LONG_RECOV), .SHORT_RECOV(SHORT_RECOV), .READ_HOLD(READ_HOLD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hwResetN(hwResetN), .strb(strb),
    .longBusy(longBusy), .drainDone(drainDone)
  );

  assign busTristate  = seqActive;
  assign accessIgnore = seqActive;
  assign rdyBusy      = !(engineBusy || longBusy);

  // Output drivers stay off while the pin is held low inside a sequence
  assert_tristate_in_reset_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busTristate && !hwResetN) |=> busTristate);
endmodule

// File: tb/flash_reset_seq_tb.sv
module flash_reset_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PMIN = 4, LREC = 20, SREC = 6, HOLD = 3;

  logic clk = 1'b0, rstN = 1'b0, hwResetN = 1'b1, engineBusy = 1'b0;
  logic abortReq, readArrayCmd, busTristate, accessIgnore, rdyBusy;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  // behavioural model state
  int lowRun = 0, highRun = HOLD, since = 1000;
  bit inSeq = 0, longMode = 0, expAbort = 0, expCmd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_reset_seq #(.PULSE_MIN(PMIN), .LONG_RECOV(LREC), .SHORT_RECOV(SREC),
                    .READ_HOLD(HOLD)) u_dut (
    .clk(clk), .rstN(rstN), .hwResetN(hwResetN), .engineBusy(engineBusy),
    .abortReq(abortReq), .readArrayCmd(readArrayCmd), .busTristate(busTristate),
    .accessIgnore(accessIgnore), .rdyBusy(rdyBusy));

  function automatic bit longNow();
    return longMode && (since < LREC);
  endfunction

  task automatic cmp(string tag, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, what, $time, act, exp);
    end
  endtask

  task automatic modelEdge(bit pin, bit busy);
    bit acc, pick;
    lowRun  = pin ? 0 : lowRun + 1;
    highRun = pin ? highRun + 1 : 0;
    acc  = (lowRun == PMIN);
    pick = busy || longNow();
    if (acc) begin
      inSeq = 1; since = 0; longMode = pick; expAbort = busy; expCmd = 1;
    end else begin
      if (since < 1000) since++;
      expAbort = 0; expCmd = 0;
      if (inSeq && since >= (longMode ? LREC : SREC) && highRun >= HOLD) inSeq = 0;
    end
  endtask

  task automatic step(bit pin, bit busy, string tag);
    @(negedge clk);
    hwResetN = pin; engineBusy = busy;
    @(posedge clk);
    modelEdge(pin, busy);
    #1;
    cmp(tag, "abortReq", abortReq, expAbort);
    cmp(tag, "readArrayCmd", readArrayCmd, expCmd);
    cmp(tag, "busTristate", busTristate, inSeq);
    cmp(tag, "accessIgnore", accessIgnore, inSeq);
    cmp(tag, "rdyBusy", rdyBusy, !(busy || longNow()));
  endtask

  task automatic run(bit pin, bit busy, int n, string tag);
    for (int i = 0; i < n; i++) step(pin, busy, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state while rstN still low
    cmp("R1", "abortReq", abortReq, 1'b0);
    cmp("R1", "readArrayCmd", readArrayCmd, 1'b0);
    cmp("R1", "busTristate", busTristate, 1'b0);
    cmp("R1", "accessIgnore", accessIgnore, 1'b0);
    cmp("R1", "rdyBusy", rdyBusy, 1'b1);
    @(negedge clk); rstN = 1'b1;
    run(1, 0, 2, "R1");
    run(1, 1, 2, "R10");
    // R2: glitch one short of the minimum with engine busy
    run(0, 1, PMIN-1, "R2");
    run(1, 1, 4, "R2");
    // R3 / R4 / R5: busy reset; engine drops busy after abort
    run(0, 1, PMIN-1, "R5");
    step(0, 1, "R3");
    run(0, 0, 2, "R4");
    run(1, 0, LREC + 4, "R6");
    run(1, 1, 3, "R10");
    run(1, 0, 2, "R10");
    // R7 / R8: idle reset with a long pulse; release hold decides
    run(0, 0, PMIN + 10, "R7");
    run(1, 0, HOLD + 4, "R8");
    // R8: idle reset with a quick release; short recovery decides
    run(0, 0, PMIN, "R8");
    run(1, 0, SREC + 4, "R8");
    // R9: re-acceptance inside a long recovery keeps it long
    run(0, 1, PMIN, "R9");
    run(1, 0, 5, "R9");
    run(0, 0, PMIN, "R9");
    run(1, 0, LREC + 6, "R9");
    // R9: idle restart inside a short recovery
    run(0, 0, PMIN, "R9");
    run(1, 0, 2, "R9");
    run(0, 0, PMIN + 1, "R9");
    run(1, 1, SREC + HOLD + 3, "R9");
    run(1, 0, 3, "R10");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule